// File: doc/BRIEF.md
# Debug State Access Port Wrapper

This block sits around a fixed-schedule iterative datapath whose iteration is a constant number of control steps long and which keeps a small bank of state registers. It lets an outside debugger overwrite and capture those state registers while the datapath runs normally, and it adds no pins. Debug words travel over the single shared data pin in the control steps that the functional traffic leaves idle. The functional input uses the first step and the functional output uses the last step.

Debug traffic is batched over a period of several iterations. A step counter and an iteration-within-period counter select the role of the pin in each step. In an armed period the wrapper fills an input buffer with new state values and, at the end of the period, copies every state register into an output buffer in one cycle. At the start of the next period it loads the whole input buffer into the state registers in one cycle, and it streams the captured values out over the pin. The state registers follow the datapath untouched in every step where no debug load is due.

Top module: `dbg_state_port`

## Requirements
- R1: A synchronous reset sets the step counter to 1 and the iteration counter to 0, and clears every state register, both buffers and all flags. While reset is held, `pin_oe` and `dbg_valid` are 0.
- R2: `step_out` counts 1 to STEPS and then wraps to 1. `iter_out` counts 0 to PERIOD-1 and advances on each wrap of the step counter. In step STEPS the pin drives `func_out` and `pin_oe` is 1.
- R3: When no debug load is due in a cycle, state register i takes `dp_next` slice i on the next edge if `dp_load[i]` is 1, and otherwise holds its value.
- R4: `pin_oe` is 1 only in step STEPS, or in a debug-output slot while captured values are pending. `pin_in` is sampled into the input buffer only in a debug-input slot of an armed period and is ignored in every other step.
- R5: For steps 2 to STEPS-1, the slot number is iter*(STEPS-2)+(step-2). Slots 0 to N-1 drive captured value i = slot. Slots N to 2N-1 load input buffer entry i = slot-N. Higher slots leave the pin idle.
- R6: `dbg_en` is sampled only in the last cycle of a period (step STEPS, iteration PERIOD-1), and it arms the whole next period. A change of `dbg_en` at any other cycle has no effect.
- R7: In step 1 of iteration 0, if a full input buffer was gathered, all state registers load their buffer entries together on that edge. This load overrides `dp_load`.
- R8: In the last cycle of an armed period, all state registers are copied into the output buffer on the same edge. The copies are driven out in the output slots of the following period, entry 0 first.
- R9: `dbg_valid` is a one-cycle pulse in the cycle after the last captured value has been driven on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_en | input | 1 | Debug request, sampled at period end |
| pin_in | input | DATA_W | Shared pin, inbound value |
| pin_out | output | DATA_W | Shared pin, outbound value |
| pin_oe | output | 1 | Shared pin drive enable |
| func_out | input | DATA_W | Datapath result for the output step |
| dp_load | input | N_STATE | Datapath load strobe per state register |
| dp_next | input | N_STATE*DATA_W | Datapath next value per state register |
| state_out | output | N_STATE*DATA_W | Current state registers, entry i at bits i*DATA_W |
| step_out | output | SW | Current control step, 1 to STEPS |
| iter_out | output | IW | Current iteration within the period |
| dbg_valid | output | 1 | Pulse after a full captured set has left |

## Verification
The pin outputs and `pin_oe` follow the counters in the same cycle. State loads, captures, buffer writes and the arming flag take effect on the edge that closes the cycle in which their condition holds. `dbg_valid` rises one cycle after the final output slot. The bench keeps its own step, iteration, buffer and arming values, updates them at each rising edge from the inputs it drove, and compares every output shortly after the falling edge, when the new register values and the freshly driven inputs have both settled.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
    // role of the shared pin in one control step
    typedef enum logic [2:0] {
        SK_IDLE,
        SK_FIN,
        SK_FOUT,
        SK_DIN,
        SK_DOUT
    } slot_kind_e;
endpackage

// File: rtl/dbgp_seq.sv
module dbgp_seq #(
    parameter int STEPS  = 7,
    parameter int PERIOD = 3,
    localparam int SW = $clog2(STEPS + 1),
    localparam int IW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] step_o,
    output logic [IW-1:0] iter_o,
    output logic          period_start_o,
    output logic          period_end_o
);
    typedef struct packed {
        logic [SW-1:0] step;
        logic [IW-1:0] iter;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (r_q.step == SW'(STEPS)) begin
            r_d.step = SW'(1);
            r_d.iter = (r_q.iter == IW'(PERIOD - 1)) ? '0 : r_q.iter + IW'(1);
        end else begin
            r_d.step = r_q.step + SW'(1);
        end
        if (rst) begin
            r_d.step = SW'(1);
            r_d.iter = '0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign step_o         = r_q.step;
    assign iter_o         = r_q.iter;
    assign period_start_o = (r_q.step == SW'(1)) && (r_q.iter == '0);
    assign period_end_o   = (r_q.step == SW'(STEPS)) && (r_q.iter == IW'(PERIOD - 1));

    // R2
    step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.step == SW'(STEPS)) |=> (r_q.step == SW'(1)));
    // R2
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.step >= SW'(1)) && (r_q.step <= SW'(STEPS)));
endmodule

// File: rtl/dbgp_slot_map.sv
module dbgp_slot_map
    import dbgp_pkg::*;
#(
    parameter int STEPS   = 7,
    parameter int PERIOD  = 3,
    parameter int N_STATE = 4,
    localparam int SW   = $clog2(STEPS + 1),
    localparam int IW   = (PERIOD > 1) ? $clog2(PERIOD) : 1,
    localparam int IXW  = (N_STATE > 1) ? $clog2(N_STATE) : 1,
    localparam int FREE = STEPS - 2
) (
    input  logic [SW-1:0]  step_i,
    input  logic [IW-1:0]  iter_i,
    output slot_kind_e     kind_o,
    output logic [IXW-1:0] idx_o
);
    int slot;

    always_comb begin
        slot   = int'(iter_i) * FREE + int'(step_i) - 2;
        kind_o = SK_IDLE;
        idx_o  = '0;
        if (int'(step_i) == 1) begin
            kind_o = SK_FIN;
        end else if (int'(step_i) == STEPS) begin
            kind_o = SK_FOUT;
        end else if (slot < N_STATE) begin
            kind_o = SK_DOUT;
            idx_o  = IXW'(slot);
        end else if (slot < 2 * N_STATE) begin
            kind_o = SK_DIN;
            idx_o  = IXW'(slot - N_STATE);
        end
    end
endmodule

// File: rtl/dbg_state_port.sv
module dbg_state_port
    import dbgp_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int N_STATE = 4,
    parameter int STEPS   = 7,
    parameter int PERIOD  = 3,
    localparam int SW  = $clog2(STEPS + 1),
    localparam int IW  = (PERIOD > 1) ? $clog2(PERIOD) : 1,
    localparam int IXW = (N_STATE > 1) ? $clog2(N_STATE) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      dbg_en,
    input  logic [DATA_W-1:0]         pin_in,
    output logic [DATA_W-1:0]         pin_out,
    output logic                      pin_oe,
    input  logic [DATA_W-1:0]         func_out,
    input  logic [N_STATE-1:0]        dp_load,
    input  logic [N_STATE*DATA_W-1:0] dp_next,
    output logic [N_STATE*DATA_W-1:0] state_out,
    output logic [SW-1:0]             step_out,
    output logic [IW-1:0]             iter_out,
    output logic                      dbg_valid
);
    typedef struct packed {
        logic [N_STATE-1:0][DATA_W-1:0] st;
        logic [N_STATE-1:0][DATA_W-1:0] ib;
        logic [N_STATE-1:0][DATA_W-1:0] ob;
        logic act;
        logic in_full;
        logic ob_full;
        logic vld;
    } core_t;

    core_t r_q, r_d;
    logic [SW-1:0]  step;
    logic [IW-1:0]  iter;
    logic           p_start, p_end;
    slot_kind_e     kind;
    logic [IXW-1:0] idx;
    logic           apply;

    dbgp_seq #(.STEPS(STEPS), .PERIOD(PERIOD)) u_seq (
        .clk(clk), .rst(rst), .step_o(step), .iter_o(iter),
        .period_start_o(p_start), .period_end_o(p_end)
    );

    dbgp_slot_map #(.STEPS(STEPS), .PERIOD(PERIOD), .N_STATE(N_STATE)) u_map (
        .step_i(step), .iter_i(iter), .kind_o(kind), .idx_o(idx)
    );

    assign apply = p_start && r_q.in_full;

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        for (int i = 0; i < N_STATE; i++) begin
            if (apply)
                r_d.st[i] = r_q.ib[i];
            else if (dp_load[i])
                r_d.st[i] = dp_next[i*DATA_W +: DATA_W];
        end
        if (kind == SK_DOUT && r_q.ob_full && idx == IXW'(N_STATE - 1)) begin
            r_d.ob_full = 1'b0;
            r_d.vld     = 1'b1;
        end
        if (p_end && r_q.act) begin
            r_d.ob      = r_q.st;
            r_d.ob_full = 1'b1;
        end
        if (kind == SK_DIN && r_q.act) begin
            r_d.ib[idx] = pin_in;
            if (idx == IXW'(N_STATE - 1))
                r_d.in_full = 1'b1;
        end
        if (apply)
            r_d.in_full = 1'b0;
        if (p_end)
            r_d.act = dbg_en;
        if (rst)
            r_d = '0;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    always_comb begin
        pin_oe  = 1'b0;
        pin_out = '0;
        if (kind == SK_FOUT) begin
            pin_oe  = 1'b1;
            pin_out = func_out;
        end else if (kind == SK_DOUT && r_q.ob_full) begin
            pin_oe  = 1'b1;
            pin_out = r_q.ob[idx];
        end
    end

    assign state_out = r_q.st;
    assign step_out  = step;
    assign iter_out  = iter;
    assign dbg_valid = r_q.vld;

    // R4
    pin_oe_slot_chk: assert property (@(posedge clk) disable iff (rst)
        pin_oe |-> (step == SW'(STEPS) || kind == SK_DOUT));
    // R9
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_valid |=> !dbg_valid);
    // R7
    bulk_load_chk: assert property (@(posedge clk) disable iff (rst)
        apply |=> (r_q.st == $past(r_q.ib)));
    // R8
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (p_end && r_q.act) |=> (r_q.ob_full && r_q.ob == $past(r_q.st)));
endmodule

// File: tb/dbg_state_port_test.sv
module dbg_state_port_test;
    localparam int DW = 8;
    localparam int N  = 4;
    localparam int ST = 7;
    localparam int PR = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dbg_en = 1'b0;
    logic [DW-1:0] pin_in = '0;
    logic [DW-1:0] func_out = '0;
    logic [N-1:0] dp_load = '0;
    logic [N*DW-1:0] dp_next = '0;
    logic [DW-1:0] pin_out;
    logic pin_oe;
    logic [N*DW-1:0] state_out;
    logic [2:0] step_out;
    logic [1:0] iter_out;
    logic dbg_valid;

    always #4 clk = ~clk;

    dbg_state_port #(.DATA_W(DW), .N_STATE(N), .STEPS(ST), .PERIOD(PR)) uut (
        .clk(clk), .rst(rst), .dbg_en(dbg_en), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .func_out(func_out), .dp_load(dp_load), .dp_next(dp_next),
        .state_out(state_out), .step_out(step_out), .iter_out(iter_out),
        .dbg_valid(dbg_valid)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model
    int m_step, m_iter, m_act, m_in_full, m_ob_full, m_vld;
    int m_st[N];
    int m_ib[N];
    int m_ob[N];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // 0 idle, 1 func in, 2 func out, 3 debug in, 4 debug out
    function automatic int slot_kind(input int s, input int it, output int ix);
        int sl;
        sl = it * (ST - 2) + s - 2;
        ix = 0;
        if (s == 1) return 1;
        if (s == ST) return 2;
        if (sl < N) begin ix = sl; return 4; end
        if (sl < 2 * N) begin ix = sl - N; return 3; end
        return 0;
    endfunction

    task automatic model_reset();
        m_step = 1; m_iter = 0; m_act = 0; m_in_full = 0; m_ob_full = 0; m_vld = 0;
        for (int i = 0; i < N; i++) begin m_st[i] = 0; m_ib[i] = 0; m_ob[i] = 0; end
    endtask

    task automatic model_edge();
        int k, ix, apply, pend;
        int old_st[N];
        k = slot_kind(m_step, m_iter, ix);
        apply = (m_step == 1 && m_iter == 0 && m_in_full != 0);
        pend  = (m_step == ST && m_iter == PR - 1);
        for (int i = 0; i < N; i++) old_st[i] = m_st[i];
        for (int i = 0; i < N; i++) begin
            if (apply) m_st[i] = m_ib[i];
            else if (dp_load[i]) m_st[i] = int'(dp_next[i*DW +: DW]);
        end
        m_vld = 0;
        if (k == 4 && m_ob_full != 0 && ix == N - 1) begin m_vld = 1; m_ob_full = 0; end
        if (pend && m_act != 0) begin
            for (int i = 0; i < N; i++) m_ob[i] = old_st[i];
            m_ob_full = 1;
        end
        if (k == 3 && m_act != 0) begin
            m_ib[ix] = int'(pin_in);
            if (ix == N - 1) m_in_full = 1;
        end
        if (apply) m_in_full = 0;
        if (pend) m_act = int'(dbg_en);
        if (m_step == ST) begin
            m_step = 1;
            m_iter = (m_iter == PR - 1) ? 0 : m_iter + 1;
        end else m_step++;
    endtask

    task automatic compare();
        int k, ix, e_oe, e_out;
        k = slot_kind(m_step, m_iter, ix);
        e_oe = 0; e_out = 0;
        if (k == 2) begin e_oe = 1; e_out = int'(func_out); end
        else if (k == 4 && m_ob_full != 0) begin e_oe = 1; e_out = m_ob[ix]; end
        chk("R2 step", int'(step_out), m_step);
        chk("R2 iter", int'(iter_out), m_iter);
        chk("R4 pin_oe", int'(pin_oe), e_oe);
        chk(k == 2 ? "R2 func pin_out" : "R5 R8 pin_out", int'(pin_out), e_out);
        chk("R9 dbg_valid", int'(dbg_valid), m_vld);
        for (int i = 0; i < N; i++)
            chk("R3 R4 R6 R7 state", int'(state_out[i*DW +: DW]), m_st[i]);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        int en;
        lfsr = 16'hACE1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 step", int'(step_out), 1);
        chk("R1 iter", int'(iter_out), 0);
        chk("R1 pin_oe", int'(pin_oe), 0);
        chk("R1 dbg_valid", int'(dbg_valid), 0);
        chk("R1 state", int'(state_out), 0);
        rst = 1'b0;
        for (int c = 0; c < 900; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            dp_load  = lfsr[3:0] & {N{(c % 5) != 0}};
            dp_next  = {lfsr, ~lfsr};
            func_out = DW'(c) ^ 8'h5A;
            pin_in   = 8'h30 + DW'(c);
            // R6: armed span, quick toggles away from period ends, late drop
            en = (c >= 40 && c < 200) || (c >= 300 && c < 340) ||
                 (c >= 500 && c < 560 && (c % 3) == 0) || (c >= 700 && c < 720);
            dbg_en = en[0];
            #1;
            compare();
            @(posedge clk);
            model_edge();
            @(negedge clk);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule